// File: doc/BRIEF.md
# Power-Domain Headswitch Sequencer

This block controls one switchable power domain. It runs from the reference-oscillator clock. It drives two groups of power switches: a small "few" group that limits inrush current and a larger "rest" group. It also drives an isolation clamp, a domain reset, a flip-flop retain enable and the clock enable into the domain. A request to power the domain up or down comes either from a collapse bit in the control register or from a hardware request pin. The finite-state machine then steps through a fixed order of timed states. Each step's wait is programmed as 2^n reference cycles.

The FSM is idle in `S_OFF` or `S_ON`. Power-up runs `S_OFF` → `S_UPWAKE` (start-up latency) → `S_FEW` (few switches on) → `S_REST` (rest switches on) → `S_RELEASE` (clamp and reset released) → `S_HOLD` (extra clock hold) → `S_ON`. Power-down runs `S_ON` → `S_DNWAKE` (start-up latency) → `S_CLKOFF` (clock gated) → `S_RESTOFF` (clamp and reset asserted, rest switches off) → `S_FEWOFF` (few switches off) → `S_OFF`. Each timed state leaves when its wait expires. The idle states leave when the selected request differs from the current level. `S_ON` also leaves when a change of the trigger mode has requested a power cycle.

Software reads the powered status and the completion flags through the same register port. A software override mode hands the switch, clamp and clock outputs to register bits.

Top module: `pd_switch_seq`

## Requirements
- R1: After reset the domain is collapsed: few_en=0, rest_en=0, clamp=1, dom_rst=1, clk_en=0, retain_ff=0. The control register (address 0x0) reads 0 and the config register (address 0x4) reads only the down-done flag, bit 15 = 1.
- R2: Control register at address 0x0 has these writable bits: 0 = collapse request (1 = off), 1 = hardware-trigger select, 2 = software override, 4/5/6/7 = override values for few/rest/clamp+reset/clock, 15:12 = clock wait, 19:16 = few wait, 23:20 = rest wait. All other bits read 0 except status bit 31. Any address other than 0x0 and 0x4 reads 0.
- R3: Each timed step lasts exactly 2^n reference cycles, where n is the relevant 4-bit wait field sampled when the step is entered. A field of 0 gives one cycle.
- R4: A new request is followed by exactly 8 cycles in which all outputs and the status keep their previous values before the first step changes anything.
- R5: Power-up order: few switches on (few wait), rest switches on (rest wait), then clamp and reset released (clock wait). The clamp stays asserted whenever the rest group is off.
- R6: After the release wait, clk_en stays 0 for 4 more cycles and then goes to 1.
- R7: Power-down order: clk_en off (clock wait), clamp and reset asserted with the rest switches off (rest wait), few switches off (few wait), then idle collapsed.
- R8: Control bit 31 reads 1 from the first cycle of `S_ON` until the last down step ends, and 0 otherwise. Config bit 16 (up-done) is 1 only in `S_ON`. Config bit 15 (down-done) is 1 only in `S_OFF`.
- R9: When hardware-trigger select is 1, hw_req (1 = on) is the request and the collapse bit is ignored. When it is 0, the collapse bit is the request and hw_req is ignored.
- R10: A write that changes the hardware-trigger select bit while the FSM is not in `S_OFF` forces one power-down/power-up cycle once the FSM reaches `S_ON`. The cycle goes back up only if the request is then on.
- R11: With software override = 1, few_en, rest_en, clamp and dom_rst, and clk_en follow control bits 4, 5, 6 and 7 in the cycle after the write. The FSM and the status keep running unaffected.
- R12: A request that changes during a sequence does not interrupt it. It is acted on only when the sequence reaches its idle state.
- R13: Config bit 11 is a read/write retain enable that drives retain_ff. Config bits 15 and 16 are read-only, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte address of the write (0x0 control, 0x4 config) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| hw_req | input | 1 | Hardware power request, 1 = on, synchronous to clk |
| few_en | output | 1 | Few headswitch group enable |
| rest_en | output | 1 | Rest headswitch group enable |
| clamp | output | 1 | Isolation clamp, 1 = clamped |
| dom_rst | output | 1 | Domain reset, 1 = held in reset |
| clk_en | output | 1 | Clock enable into the domain |
| retain_ff | output | 1 | Flip-flop retain enable |

## Verification
The assertions assume that hw_req is already synchronous to the reference clock and that the wait fields are not rewritten while a sequence is running. Each step samples its own field on entry, so a mid-sequence rewrite would shift later steps and nothing else. The stimulus therefore changes the wait fields only while the FSM is idle with no request pending. It freely moves the collapse bit, the trigger-select bit, hw_req and the override bits at any point, including in the middle of a sequence. The reference model advances one cycle per clock edge and is compared against every output and the current read word on each cycle.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    localparam int WAIT_W = 4;
    localparam int CNT_W  = 1 << WAIT_W;

    // control register bit positions (address 0x0)
    localparam int CB_COLLAPSE = 0;
    localparam int CB_HWTRIG   = 1;
    localparam int CB_OVR      = 2;
    localparam int CB_OV_FEW   = 4;
    localparam int CB_OV_REST  = 5;
    localparam int CB_OV_CLAMP = 6;
    localparam int CB_OV_CLK   = 7;
    localparam int CB_WCLK     = 12;
    localparam int CB_WFEW     = 16;
    localparam int CB_WREST    = 20;
    localparam int CB_POWERED  = 31;
    localparam logic [31:0] CTL_WMASK = 32'h00FF_F0F7;

    // config register bit positions (address 0x4)
    localparam int FB_RETAIN = 11;
    localparam int FB_DNDONE = 15;
    localparam int FB_UPDONE = 16;

    typedef enum logic [3:0] {
        S_OFF,
        S_UPWAKE,
        S_FEW,
        S_REST,
        S_RELEASE,
        S_HOLD,
        S_ON,
        S_DNWAKE,
        S_CLKOFF,
        S_RESTOFF,
        S_FEWOFF
    } seq_state_e;

    typedef struct packed {
        logic few;
        logic rest;
        logic clamp;
        logic clk;
    } sw_drive_t;

endpackage

// File: rtl/pd_seq_timer.sv
module pd_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == '0);

    // R3: without a load the count only moves downward
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/pd_seq_regs.sv
module pd_seq_regs
    import pd_seq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              powered,
    input  logic              up_done,
    input  logic              dn_done,
    input  logic              fsm_off,
    output logic              collapse,
    output logic              hwtrig,
    output logic              ovr,
    output sw_drive_t         ovr_drv,
    output logic [WAIT_W-1:0] wait_few,
    output logic [WAIT_W-1:0] wait_rest,
    output logic [WAIT_W-1:0] wait_clk,
    output logic              retain,
    output logic              bounce
);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(4);

    logic [31:0] ctl_q;
    logic        retain_q;
    logic        bounce_q;
    logic        ctl_wr, cfg_wr;

    assign ctl_wr = wr_en && (wr_addr == A_CTL);
    assign cfg_wr = wr_en && (wr_addr == A_CFG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            retain_q <= 1'b0;
        end else begin
            if (ctl_wr) ctl_q    <= wr_data & CTL_WMASK;
            if (cfg_wr) retain_q <= wr_data[FB_RETAIN];
        end
    end

    // power-cycle request raised by a trigger-mode change
    always_ff @(posedge clk) begin
        if (!rst_n)
            bounce_q <= 1'b0;
        else if (fsm_off)
            bounce_q <= 1'b0;
        else if (ctl_wr && (wr_data[CB_HWTRIG] != ctl_q[CB_HWTRIG]))
            bounce_q <= 1'b1;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTL) begin
            rd_data             = ctl_q;
            rd_data[CB_POWERED] = powered;
        end else if (rd_addr == A_CFG) begin
            rd_data[FB_RETAIN] = retain_q;
            rd_data[FB_DNDONE] = dn_done;
            rd_data[FB_UPDONE] = up_done;
        end
    end

    assign collapse      = ctl_q[CB_COLLAPSE];
    assign hwtrig        = ctl_q[CB_HWTRIG];
    assign ovr           = ctl_q[CB_OVR];
    assign ovr_drv.few   = ctl_q[CB_OV_FEW];
    assign ovr_drv.rest  = ctl_q[CB_OV_REST];
    assign ovr_drv.clamp = ctl_q[CB_OV_CLAMP];
    assign ovr_drv.clk   = ctl_q[CB_OV_CLK];
    assign wait_few      = ctl_q[CB_WFEW  +: WAIT_W];
    assign wait_rest     = ctl_q[CB_WREST +: WAIT_W];
    assign wait_clk      = ctl_q[CB_WCLK  +: WAIT_W];
    assign retain        = retain_q;
    assign bounce        = bounce_q;

    // R10: a pending power cycle is dropped once the domain sits collapsed
    p_bounce_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_off |=> !bounce);

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import pd_seq_pkg::*;
#(
    parameter int START_LAT = 8,
    parameter int CLK_HOLD  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_on,
    input  logic              bounce,
    input  logic [WAIT_W-1:0] wait_few,
    input  logic [WAIT_W-1:0] wait_rest,
    input  logic [WAIT_W-1:0] wait_clk,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output sw_drive_t         drv,
    output logic              powered,
    output logic              up_done,
    output logic              dn_done,
    output logic              is_off
);
    localparam logic [CNT_W-1:0] LAT_CNT  = CNT_W'(START_LAT - 1);
    localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(CLK_HOLD - 1);

    seq_state_e st, nxt;

    function automatic logic [CNT_W-1:0] span(input logic [WAIT_W-1:0] n);
        logic [CNT_W-1:0] one_c;
        one_c = CNT_W'(1);
        return (one_c << n) - one_c;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_OFF;
        else
            st <= nxt;
    end

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            S_OFF:     if (want_on)            begin nxt = S_UPWAKE;  tmr_load = 1'b1; tmr_val = LAT_CNT; end
            S_UPWAKE:  if (tmr_done)           begin nxt = S_FEW;     tmr_load = 1'b1; tmr_val = span(wait_few); end
            S_FEW:     if (tmr_done)           begin nxt = S_REST;    tmr_load = 1'b1; tmr_val = span(wait_rest); end
            S_REST:    if (tmr_done)           begin nxt = S_RELEASE; tmr_load = 1'b1; tmr_val = span(wait_clk); end
            S_RELEASE: if (tmr_done)           begin nxt = S_HOLD;    tmr_load = 1'b1; tmr_val = HOLD_CNT; end
            S_HOLD:    if (tmr_done)                 nxt = S_ON;
            S_ON:      if (!want_on || bounce) begin nxt = S_DNWAKE;  tmr_load = 1'b1; tmr_val = LAT_CNT; end
            S_DNWAKE:  if (tmr_done)           begin nxt = S_CLKOFF;  tmr_load = 1'b1; tmr_val = span(wait_clk); end
            S_CLKOFF:  if (tmr_done)           begin nxt = S_RESTOFF; tmr_load = 1'b1; tmr_val = span(wait_rest); end
            S_RESTOFF: if (tmr_done)           begin nxt = S_FEWOFF;  tmr_load = 1'b1; tmr_val = span(wait_few); end
            S_FEWOFF:  if (tmr_done)                 nxt = S_OFF;
            default:                                 nxt = S_OFF;
        endcase
    end

    always_comb begin
        drv     = '{few: 1'b0, rest: 1'b0, clamp: 1'b1, clk: 1'b0};
        powered = 1'b0;
        unique case (st)
            S_OFF, S_UPWAKE: ;
            S_FEW:              drv = '{few: 1'b1, rest: 1'b0, clamp: 1'b1, clk: 1'b0};
            S_REST:             drv = '{few: 1'b1, rest: 1'b1, clamp: 1'b1, clk: 1'b0};
            S_RELEASE, S_HOLD:  drv = '{few: 1'b1, rest: 1'b1, clamp: 1'b0, clk: 1'b0};
            S_ON, S_DNWAKE: begin
                drv     = '{few: 1'b1, rest: 1'b1, clamp: 1'b0, clk: 1'b1};
                powered = 1'b1;
            end
            S_CLKOFF: begin
                drv     = '{few: 1'b1, rest: 1'b1, clamp: 1'b0, clk: 1'b0};
                powered = 1'b1;
            end
            S_RESTOFF: begin
                drv     = '{few: 1'b1, rest: 1'b0, clamp: 1'b1, clk: 1'b0};
                powered = 1'b1;
            end
            S_FEWOFF: begin
                drv     = '{few: 1'b0, rest: 1'b0, clamp: 1'b1, clk: 1'b0};
                powered = 1'b1;
            end
            default: ;
        endcase
    end

    assign up_done = (st == S_ON);
    assign dn_done = (st == S_OFF);
    assign is_off  = (st == S_OFF);

    // R5: the clamp covers every state where the rest group is off
    p_clamp_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !drv.rest |-> drv.clamp);
    // R6: the clock runs only with all switches on and the clamp open
    p_clk_needs_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drv.clk |-> (drv.few && drv.rest && !drv.clamp));
    // R7: the rest group is never on without the few group
    p_few_under_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv.rest |-> drv.few);
    // R8: status rises together with up-done and the running clock
    p_status_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |-> (up_done && drv.clk));
    // R8: status falls together with down-done
    p_status_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered) |-> dn_done);
    // R4: leaving an idle state holds the outputs for the start-up window
    p_wake_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DNWAKE) |-> drv.clk);

endmodule

// File: rtl/pd_switch_seq.sv
module pd_switch_seq
    import pd_seq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int START_LAT = 8,
    parameter int CLK_HOLD  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              hw_req,
    output logic              few_en,
    output logic              rest_en,
    output logic              clamp,
    output logic              dom_rst,
    output logic              clk_en,
    output logic              retain_ff
);
    logic              collapse, hwtrig, ovr, retain, bounce;
    sw_drive_t         ovr_drv, fsm_drv, out_drv;
    logic [WAIT_W-1:0] wait_few, wait_rest, wait_clk;
    logic              powered, up_done, dn_done, is_off;
    logic              want_on;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;

    pd_seq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .powered   (powered),
        .up_done   (up_done),
        .dn_done   (dn_done),
        .fsm_off   (is_off),
        .collapse  (collapse),
        .hwtrig    (hwtrig),
        .ovr       (ovr),
        .ovr_drv   (ovr_drv),
        .wait_few  (wait_few),
        .wait_rest (wait_rest),
        .wait_clk  (wait_clk),
        .retain    (retain),
        .bounce    (bounce)
    );

    // request source selection
    assign want_on = hwtrig ? hw_req : !collapse;

    pd_seq_fsm #(.START_LAT(START_LAT), .CLK_HOLD(CLK_HOLD)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_on   (want_on),
        .bounce    (bounce),
        .wait_few  (wait_few),
        .wait_rest (wait_rest),
        .wait_clk  (wait_clk),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .drv       (fsm_drv),
        .powered   (powered),
        .up_done   (up_done),
        .dn_done   (dn_done),
        .is_off    (is_off)
    );

    pd_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign out_drv   = ovr ? ovr_drv : fsm_drv;
    assign few_en    = out_drv.few;
    assign rest_en   = out_drv.rest;
    assign clamp     = out_drv.clamp;
    assign dom_rst   = out_drv.clamp;
    assign clk_en    = out_drv.clk;
    assign retain_ff = retain;

    // R11: under override the outputs track the register, not the FSM
    p_override_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> (clk_en == ovr_drv.clk && few_en == ovr_drv.few));

endmodule

// File: tb/tb_pd_switch_seq.sv
module tb_pd_switch_seq;

    localparam real HALF = 2.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic        hw_req = 1'b0;
    logic [31:0] rd_data;
    logic        few_en, rest_en, clamp, dom_rst, clk_en, retain_ff;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #(HALF) clk = ~clk;

    pd_switch_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_req(hw_req), .few_en(few_en), .rest_en(rest_en), .clamp(clamp),
        .dom_rst(dom_rst), .clk_en(clk_en), .retain_ff(retain_ff)
    );

    // reference model: vector = {pw, upd, dnd, few, rest, clamp, clk}
    logic [6:0]  q[$];
    bit          m_on  = 0;
    bit          m_bnc = 0;
    bit          m_ret = 0;
    logic [31:0] m_ctl = '0;

    function automatic logic [6:0] idle_vec(bit on);
        return on ? 7'b110_1101 : 7'b001_0010;
    endfunction

    function automatic bit m_target();
        return m_ctl[1] ? hw_req : !m_ctl[0];
    endfunction

    task automatic push_n(int n, logic [6:0] v);
        for (int i = 0; i < n; i++) q.push_back(v);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_on = 0; m_bnc = 0; m_ret = 0; m_ctl = '0;
        end else begin
            bit off_now;
            bit tgt;
            int wf, wr, wc;
            off_now = (q.size() == 0) && !m_on;
            tgt = m_target();
            wc = 1 << m_ctl[15:12];
            wf = 1 << m_ctl[19:16];
            wr = 1 << m_ctl[23:20];
            if (q.size() > 0) begin
                void'(q.pop_front());
            end else if (m_on && (!tgt || m_bnc)) begin
                push_n(8,  7'b100_1101);
                push_n(wc, 7'b100_1100);
                push_n(wr, 7'b100_1010);
                push_n(wf, 7'b100_0010);
                m_on = 0;
            end else if (!m_on && tgt) begin
                push_n(8,  7'b000_0010);
                push_n(wf, 7'b000_1010);
                push_n(wr, 7'b000_1110);
                push_n(wc + 4, 7'b000_1100);
                m_on = 1;
            end
            if (off_now) m_bnc = 0;
            else if (wr_en && wr_addr == 4'h0 && wr_data[1] != m_ctl[1]) m_bnc = 1;
            if (wr_en && wr_addr == 4'h0) m_ctl = wr_data & 32'h00FF_F0F7;
            if (wr_en && wr_addr == 4'h4) m_ret = wr_data[11];
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [6:0]  v;
            logic [3:0]  o_exp, o_act;
            logic [31:0] r_exp;
            v = (q.size() > 0) ? q[0] : idle_vec(m_on);
            o_exp = m_ctl[2] ? {m_ctl[4], m_ctl[5], m_ctl[6], m_ctl[7]} : v[3:0];
            o_act = {few_en, rest_en, clamp, clk_en};
            if (rd_addr == 4'h0)      r_exp = m_ctl | {v[6], 31'b0};
            else if (rd_addr == 4'h4) r_exp = (32'(v[5]) << 16) | (32'(v[4]) << 15) | (32'(m_ret) << 11);
            else                      r_exp = '0;
            chk(o_act == o_exp && dom_rst == clamp && retain_ff == m_ret && rd_data == r_exp,
                cur_req, "outputs/read",
                {o_act, dom_rst, retain_ff, 26'b0} ^ rd_data,
                {o_exp, o_exp[1], m_ret, 26'b0} ^ r_exp);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 150000; i++) begin
            @(negedge clk);
            if (q.size() == 0 && m_target() == m_on && !m_bnc) break;
        end
        idle(3);
    endtask

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        chk(!few_en && !rest_en && clamp && dom_rst && !clk_en && !retain_ff,
            "R1", "reset outputs", {few_en, rest_en, clamp, dom_rst, clk_en, retain_ff},
            6'b001100);
        chk(rd_data == 32'h0, "R1", "reset control", rd_data, 32'h0);
        idle(4);

        // R2: unwritable bits ignored, other addresses read zero
        cur_req = "R2";
        wr(4'h0, 32'hFF00_0F09 | 32'h1);
        idle(4);
        rd_addr = 4'h8; idle(3); rd_addr = 4'h0;
        wr(4'h0, 32'h0000_0001);

        // R5/R6 with one-cycle waits: power up
        cur_req = "R5";
        wr(4'h0, 32'h0000_0000);
        settle();
        // R7 power down
        cur_req = "R7";
        wr(4'h0, 32'h0000_0001);
        settle();

        // R3: distinct wait fields (rest=3, few=2, clk=1)
        cur_req = "R3";
        wr(4'h0, 32'h0032_1001);
        idle(3);
        wr(4'h0, 32'h0032_1000);
        settle();
        // R8: completion flags read through the config address
        cur_req = "R8";
        rd_addr = 4'h4;
        wr(4'h0, 32'h0032_1001);
        settle();
        // R6: longer clock wait, observed during power-up
        cur_req = "R6";
        wr(4'h0, 32'h0010_4000);
        settle();
        rd_addr = 4'h0;

        // R4: request returns mid-latency; full down then up follow
        cur_req = "R4";
        wr(4'h0, 32'h0010_4001);
        idle(2);
        wr(4'h0, 32'h0010_4000);
        settle();

        // R12: request flips in the middle of a power-down
        cur_req = "R12";
        wr(4'h0, 32'h0000_0001);
        idle(10);
        wr(4'h0, 32'h0000_0000);
        settle();
        wr(4'h0, 32'h0000_0001);
        settle();

        // R9: hardware trigger; collapse bit ignored, hw_req followed
        cur_req = "R9";
        wr(4'h0, 32'h0000_0003);
        idle(12);
        hw_req = 1'b1;
        settle();
        wr(4'h0, 32'h0000_0002);
        idle(12);
        hw_req = 1'b0;
        settle();
        wr(4'h0, 32'h0000_0000);
        settle();
        hw_req = 1'b1; idle(12); hw_req = 1'b0; idle(12);

        // R10: trigger-mode change while powered forces a power cycle
        cur_req = "R10";
        hw_req = 1'b1;
        wr(4'h0, 32'h0000_0002);
        settle();
        wr(4'h0, 32'h0000_0000);
        settle();

        // R11: override drives the outputs directly
        cur_req = "R11";
        wr(4'h0, 32'h0000_0054);
        idle(6);
        wr(4'h0, 32'h0000_00A5);
        idle(20);
        wr(4'h0, 32'h0000_0001);
        settle();

        // R13: retain bit writable, completion flags not
        cur_req = "R13";
        rd_addr = 4'h4;
        wr(4'h4, 32'h0001_8800);
        idle(4);
        wr(4'h4, 32'h0001_8000);
        idle(4);
        rd_addr = 4'h0;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule